// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block stores one priority value per interrupt line for up to 240 lines. The values are packed four per 32-bit word and reached through a small memory-mapped port with a per-byte write mask and a privilege flag. Software can program or read any single priority byte without disturbing its neighbours. Only the upper four bits of each byte are kept. The lower four bits always read back as zero.

Alongside the register file, a selector watches the pending and enable vectors that arrive on plain input buses. It reports, from a register, the most urgent interrupt that is both pending and enabled. A downstream interrupt controller can consume that index and its priority directly. A numerically smaller priority is more urgent. Among equal priorities, the smaller interrupt number wins.

Top module: `prio_bank`

## Requirements
- R1: After reset, every priority word reads 0x00000000 and `win_valid_o` is 0.
- R2: Word x (0..59) sits at byte offset 0x400 + 4*x. Byte lane l of that word holds the priority of interrupt 4*x + l in bits [8*l+7:8*l]. `addr_i[1:0]` is ignored.
- R3: Only bits [7:4] of each priority byte are stored. Bits [3:0] of every read word and of `win_prio_o` are zero, and writes to those bits are discarded.
- R4: A privileged write updates exactly the byte lanes whose `be_i` bit is 1. The other lanes keep their values.
- R5: An access with `priv_i` = 0 changes no state and returns read data 0. `err_o` is 1 in the cycle after such a request, and 0 in the cycle after any privileged request or idle cycle.
- R6: A privileged access to an offset below 0x400 or at or above 0x4F0 changes no state, returns read data 0 and raises no error.
- R7: The selector considers only interrupts that are both pending and enabled. It reports the one whose priority value is smallest.
- R8: When candidates share the smallest priority, the lowest interrupt number is reported.
- R9: `win_valid_o` is 0 whenever the previous cycle had no interrupt that was both pending and enabled.
- R10: `win_valid_o`, `win_id_o` and `win_prio_o` reflect the pending, enable and priority state one clock after it changes. In the cycle right after a priority write, they still show the old result.
- R11: Read data for a request accepted at a clock edge appears on `rdata_o` for the following cycle only. In all other cycles `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | Privileged access flag |
| addr_i | input | 12 | Byte offset from block base |
| be_i | input | 4 | Byte lane write mask |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the request |
| err_o | output | 1 | Pulses for a rejected unprivileged access |
| pend_i | input | 240 | Pending flag per interrupt |
| en_i | input | 240 | Enable flag per interrupt |
| win_valid_o | output | 1 | A pending and enabled interrupt exists |
| win_id_o | output | 8 | Number of the most urgent candidate |
| win_prio_o | output | 8 | Priority byte of that candidate |

## Verification
The bench writes all-ones and partial masks, then checks that low nibbles come back zero and untouched lanes survive. A design that stored full bytes, or wrote every lane, would return the wrong word. Unprivileged and out-of-window accesses are aimed at live registers, including offsets that alias word 0 or word 59 if the decoder drops address bits, and the registers are read back afterwards. A leaking decoder would show up as a changed priority. For the selector, the bench uses an equal-priority pair to catch a tie broken toward the higher index, a disabled but pending line to catch a missing enable mask, and a sample taken right after a priority write to catch a selector that is one cycle early or late.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;
  localparam int LANES  = BUS_DW / 8;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic              req;
    logic              we;
    logic              priv;
    logic [BUS_AW-1:0] addr;
    logic [LANES-1:0]  be;
    logic [BUS_DW-1:0] wdata;
  } bus_req_t;
endpackage

// File: rtl/prio_store.sv
module prio_store
  import prio_bank_pkg::*;
#(
  parameter int              NUM_IRQ   = 240,
  parameter int              PRIO_BITS = 4,
  parameter logic [BUS_AW-1:0] BASE_OFF = 12'h400
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  bus_req_t                           bus_i,
  output logic [BUS_DW-1:0]                  rdata_o,
  output logic                               err_o,
  output logic [NUM_IRQ-1:0][PRIO_BITS-1:0]  prio_o
);
  localparam int NUM_REGS = NUM_IRQ / LANES;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int PAD      = FIELD_W - PRIO_BITS;
  localparam logic [BUS_AW-1:0] LIMIT = BASE_OFF + BUS_AW'(LANES * NUM_REGS);

  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_q, prio_d;
  logic [NUM_IRQ-1:0]                fld_we;
  logic [BUS_AW-1:0]                 word_off;
  logic [REG_W-1:0]                  reg_idx;
  logic                              in_range, acc_ok, prio_en;
  logic [BUS_DW-1:0]                 rd_word, rdata_d;
  logic                              err_d;
  logic                              unused_bits;

  // Address decode
  always_comb begin
    word_off = bus_i.addr - BASE_OFF;
    reg_idx  = word_off[REG_W+1:2];
    in_range = (bus_i.addr >= BASE_OFF) && (bus_i.addr < LIMIT);
    acc_ok   = bus_i.req && bus_i.priv && in_range;
    prio_en  = acc_ok && bus_i.we;
  end
  assign unused_bits = ^{word_off[1:0], word_off[BUS_AW-1:REG_W+2]};

  // Per-field write enables
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_fld
    assign fld_we[i] = prio_en && bus_i.be[i % LANES]
                       && (reg_idx == REG_W'(i / LANES));
  end

  // Next state of the priority fields: upper bits of each lane only
  always_comb begin
    prio_d = prio_q;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (fld_we[i]) prio_d[i] = bus_i.wdata[(i % LANES) * FIELD_W + PAD +: PRIO_BITS];
    end
  end

  // Read word assembly
  always_comb begin
    rd_word = '0;
    if (in_range) begin
      for (int l = 0; l < LANES; l++) begin
        rd_word[l * FIELD_W +: FIELD_W] =
          FIELD_W'(prio_q[int'(reg_idx) * LANES + l]) << PAD;
      end
    end
    rdata_d = (acc_ok && !bus_i.we) ? rd_word : '0;
    err_d   = bus_i.req && !bus_i.priv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
    end else if (prio_en) begin
      prio_q <= prio_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      rdata_o <= rdata_d;
      err_o   <= err_d;
    end
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_IRQ   = 240,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = $clog2(NUM_IRQ)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio_i,
  input  logic [NUM_IRQ-1:0]                pend_i,
  input  logic [NUM_IRQ-1:0]                en_i,
  output logic                              win_valid_o,
  output logic [ID_W-1:0]                   win_id_o,
  output logic [PRIO_BITS-1:0]              win_prio_o
);
  logic [NUM_IRQ-1:0]   cand;
  logic                 best_valid;
  logic [ID_W-1:0]      best_id;
  logic [PRIO_BITS-1:0] best_prio;

  // Linear scan: strict compare keeps the lowest index on ties
  always_comb begin
    cand       = pend_i & en_i;
    best_valid = 1'b0;
    best_id    = '0;
    best_prio  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (cand[i] && (!best_valid || (prio_i[i] < best_prio))) begin
        best_valid = 1'b1;
        best_id    = ID_W'(i);
        best_prio  = prio_i[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_id_o    <= '0;
      win_prio_o  <= '0;
    end else begin
      win_valid_o <= best_valid;
      win_id_o    <= best_id;
      win_prio_o  <= best_prio;
    end
  end
endmodule

// File: rtl/prio_bank.sv
module prio_bank
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ   = 240,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               priv_i,
  input  logic [BUS_AW-1:0]  addr_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [BUS_DW-1:0]  wdata_i,
  output logic [BUS_DW-1:0]  rdata_o,
  output logic               err_o,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output logic               win_valid_o,
  output logic [ID_W-1:0]    win_id_o,
  output logic [FIELD_W-1:0] win_prio_o
);
  localparam int PAD = FIELD_W - PRIO_BITS;

  logic [1:0]                        rst_sync_q;
  logic                              rst_sync_n;
  bus_req_t                          bus;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
  logic [PRIO_BITS-1:0]              win_prio;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    bus.req   = req_i;
    bus.we    = we_i;
    bus.priv  = priv_i;
    bus.addr  = addr_i;
    bus.be    = be_i;
    bus.wdata = wdata_i;
  end

  prio_store #(
    .NUM_IRQ  (NUM_IRQ),
    .PRIO_BITS(PRIO_BITS)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .bus_i  (bus),
    .rdata_o(rdata_o),
    .err_o  (err_o),
    .prio_o (prio)
  );

  prio_arbiter #(
    .NUM_IRQ  (NUM_IRQ),
    .PRIO_BITS(PRIO_BITS),
    .ID_W     (ID_W)
  ) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .prio_i     (prio),
    .pend_i     (pend_i),
    .en_i       (en_i),
    .win_valid_o(win_valid_o),
    .win_id_o   (win_id_o),
    .win_prio_o (win_prio)
  );

  assign win_prio_o = FIELD_W'(win_prio) << PAD;
endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ   = 240,
  parameter int PRIO_BITS = 4,
  parameter int ID_W      = $clog2(NUM_IRQ)
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               req_i,
  input logic               we_i,
  input logic               priv_i,
  input logic [BUS_AW-1:0]  addr_i,
  input logic [BUS_DW-1:0]  rdata_o,
  input logic               err_o,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] en_i,
  input logic               win_valid_o,
  input logic [ID_W-1:0]    win_id_o,
  input logic [FIELD_W-1:0] win_prio_o
);
  localparam int PAD = FIELD_W - PRIO_BITS;
  localparam logic [BUS_AW-1:0] LO = 12'h400;
  localparam logic [BUS_AW-1:0] HI = LO + BUS_AW'(NUM_IRQ);

  function automatic logic [BUS_DW-1:0] low_mask();
    logic [BUS_DW-1:0] m;
    for (int b = 0; b < BUS_DW; b++) m[b] = ((b % FIELD_W) < PAD);
    return m;
  endfunction
  localparam logic [BUS_DW-1:0] LOW_M = low_mask();

  logic [NUM_IRQ-1:0] cand_d;
  logic               outside;
  assign outside = (addr_i < LO) || (addr_i >= HI);

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cand_d <= '0;
    else        cand_d <= pend_i & en_i;
  end

  AST_UNPRIV_ERR:       assert property (@(posedge clk_i) disable iff (!rst_n) (req_i && !priv_i) |=> err_o); // R5
  AST_ERR_CAUSE:        assert property (@(posedge clk_i) disable iff (!rst_n) err_o |-> $past(req_i && !priv_i)); // R5
  AST_UNPRIV_RD_ZERO:   assert property (@(posedge clk_i) disable iff (!rst_n) (req_i && !priv_i) |=> (rdata_o == '0)); // R5
  AST_OUTSIDE_RD_ZERO:  assert property (@(posedge clk_i) disable iff (!rst_n) (req_i && outside) |=> (rdata_o == '0)); // R6
  AST_RD_LOW_ZERO:      assert property (@(posedge clk_i) disable iff (!rst_n) ((rdata_o & LOW_M) == '0)); // R3
  AST_IDLE_RD_ZERO:     assert property (@(posedge clk_i) disable iff (!rst_n) (!req_i || we_i) |=> (rdata_o == '0)); // R11
  AST_WIN_VALID:        assert property (@(posedge clk_i) disable iff (!rst_n) (cand_d == '0) |-> !win_valid_o); // R9
  AST_WIN_IS_CAND:      assert property (@(posedge clk_i) disable iff (!rst_n) win_valid_o |-> cand_d[win_id_o]); // R7
  AST_WIN_PRIO_LOW:     assert property (@(posedge clk_i) disable iff (!rst_n) ((win_prio_o & LOW_M[FIELD_W-1:0]) == '0)); // R3
endmodule

bind prio_bank prio_bank_chk #(
  .NUM_IRQ  (NUM_IRQ),
  .PRIO_BITS(PRIO_BITS),
  .ID_W     (ID_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .req_i      (req_i),
  .we_i       (we_i),
  .priv_i     (priv_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .err_o      (err_o),
  .pend_i     (pend_i),
  .en_i       (en_i),
  .win_valid_o(win_valid_o),
  .win_id_o   (win_id_o),
  .win_prio_o (win_prio_o)
);

// File: tb/prio_bank_test.sv
module prio_bank_test;
  localparam int N = 240;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          req_i, we_i, priv_i;
  logic [11:0]   addr_i;
  logic [3:0]    be_i;
  logic [31:0]   wdata_i, rdata_o;
  logic          err_o;
  logic [N-1:0]  pend_i, en_i;
  logic          win_valid_o;
  logic [7:0]    win_id_o, win_prio_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] prio_m [N];

  always #2.5 clk_i = ~clk_i;

  prio_bank uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .priv_i(priv_i),
    .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o),
    .pend_i(pend_i), .en_i(en_i), .win_valid_o(win_valid_o), .win_id_o(win_id_o),
    .win_prio_o(win_prio_o)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [11:0] a);
    return (a >= 12'h400) && (a < 12'h4F0);
  endfunction

  function automatic logic [31:0] exp_word(input logic [11:0] a);
    int x;
    if (!in_win(a)) return 32'h0;
    x = (int'(a) - 'h400) / 4;
    return {prio_m[4*x+3], prio_m[4*x+2], prio_m[4*x+1], prio_m[4*x]};
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d, input logic pv);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; priv_i = pv; addr_i = a; be_i = be; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
    if (pv && in_win(a)) begin
      for (int l = 0; l < 4; l++)
        if (be[l]) prio_m[(int'(a) - 'h400) / 4 * 4 + l] = d[l*8 +: 8] & 8'hF0;
    end
  endtask

  task automatic bus_read(input logic [11:0] a, input logic pv, output logic [31:0] d, output logic e);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; priv_i = pv; addr_i = a; be_i = 4'h0;
    @(negedge clk_i);
    d = rdata_o; e = err_o;
    req_i = 1'b0;
  endtask

  task automatic read_chk(input logic [11:0] a, input string tag);
    logic [31:0] d; logic e;
    bus_read(a, 1'b1, d, e);
    check(d == exp_word(a), tag, d, exp_word(a));
  endtask

  task automatic win_chk(input string tag);
    logic v; logic [7:0] id, pr;
    v = 1'b0; id = 8'h0; pr = 8'h0;
    for (int i = 0; i < N; i++)
      if (pend_i[i] && en_i[i] && (!v || prio_m[i] < pr)) begin
        v = 1'b1; id = 8'(i); pr = prio_m[i];
      end
    check(win_valid_o == v, {tag, " valid"}, 32'(win_valid_o), 32'(v));
    if (v) begin
      check(win_id_o == id, {tag, " id"}, 32'(win_id_o), 32'(id));
      check(win_prio_o == pr, {tag, " prio"}, 32'(win_prio_o), 32'(pr));
    end
  endtask

  task automatic t_reset;
    read_chk(12'h400, "R1 word0 reset");
    read_chk(12'h428, "R1 word10 reset");
    read_chk(12'h4EC, "R1 word59 reset");
    check(win_valid_o == 1'b0, "R1 valid reset", 32'(win_valid_o), 32'h0);
  endtask

  task automatic t_map;
    bus_write(12'h414, 4'hF, 32'h40302010, 1'b1);
    read_chk(12'h414, "R2 word5 lanes");
    read_chk(12'h410, "R2 word4 untouched");
    bus_write(12'h4EC, 4'hF, 32'hA0B0C0D0, 1'b1);
    read_chk(12'h4EF, "R2 word59 low addr bits ignored");
  endtask

  task automatic t_nibble;
    bus_write(12'h404, 4'hF, 32'hFFFFFFFF, 1'b1);
    read_chk(12'h404, "R3 low nibbles zero");
    check(exp_word(12'h404) == 32'hF0F0F0F0, "R3 model", exp_word(12'h404), 32'hF0F0F0F0);
  endtask

  task automatic t_be;
    bus_write(12'h404, 4'b0101, 32'h11223344, 1'b1);
    read_chk(12'h404, "R4 lanes 0 and 2 only");
    bus_write(12'h404, 4'b0000, 32'h00000000, 1'b1);
    read_chk(12'h404, "R4 empty mask");
  endtask

  task automatic t_unpriv;
    logic [31:0] d; logic e;
    bus_write(12'h404, 4'hF, 32'h00000000, 1'b0);
    check(err_o == 1'b1, "R5 err after unpriv write", 32'(err_o), 32'h1);
    @(negedge clk_i);
    check(err_o == 1'b0, "R5 err one cycle", 32'(err_o), 32'h0);
    bus_read(12'h404, 1'b0, d, e);
    check(d == 32'h0, "R5 unpriv read zero", d, 32'h0);
    check(e == 1'b1, "R5 unpriv read err", 32'(e), 32'h1);
    read_chk(12'h404, "R5 write ignored");
  endtask

  task automatic t_range;
    logic [31:0] d; logic e;
    bus_write(12'h400, 4'hF, 32'h10203040, 1'b1);
    bus_write(12'h4F0, 4'hF, 32'hFFFFFFFF, 1'b1);
    check(err_o == 1'b0, "R6 no err above", 32'(err_o), 32'h0);
    bus_write(12'h3FC, 4'hF, 32'hFFFFFFFF, 1'b1);
    bus_write(12'h000, 4'hF, 32'hFFFFFFFF, 1'b1);
    bus_read(12'h4F0, 1'b1, d, e);
    check(d == 32'h0, "R6 read above zero", d, 32'h0);
    check(e == 1'b0, "R6 read no err", 32'(e), 32'h0);
    read_chk(12'h400, "R6 word0 unchanged");
    read_chk(12'h4EC, "R6 word59 unchanged");
    @(negedge clk_i);
    check(rdata_o == 32'h0, "R11 rdata one cycle", rdata_o, 32'h0);
  endtask

  task automatic t_arb;
    @(negedge clk_i);
    pend_i = '1; en_i = '0;
    @(negedge clk_i);
    win_chk("R7 R9 pending but disabled");
    pend_i = '0;
    bus_write(12'h404, 4'b1000, 32'h30000000, 1'b1);  // IRQ7 = 0x30
    bus_write(12'h464, 4'b0001, 32'h00000030, 1'b1);  // IRQ100 = 0x30
    bus_write(12'h4E4, 4'b0100, 32'h00500000, 1'b1);  // IRQ230 = 0x50
    @(negedge clk_i);
    pend_i[7] = 1'b1; pend_i[100] = 1'b1; pend_i[230] = 1'b1;
    en_i[7] = 1'b1; en_i[100] = 1'b1; en_i[230] = 1'b1; en_i[50] = 1'b1;
    @(negedge clk_i);
    win_chk("R8 tie lower index");
    check(win_id_o == 8'd7, "R8 tie id", 32'(win_id_o), 32'd7);
    bus_write(12'h464, 4'b0001, 32'h0000001F, 1'b1);  // IRQ100 = 0x10
    check(win_id_o == 8'd7, "R10 stale after write", 32'(win_id_o), 32'd7);
    @(negedge clk_i);
    win_chk("R10 R7 after write");
    check(win_id_o == 8'd100, "R7 lowest value", 32'(win_id_o), 32'd100);
    en_i[100] = 1'b0;
    #1;
    check(win_id_o == 8'd100, "R10 before edge", 32'(win_id_o), 32'd100);
    @(negedge clk_i);
    win_chk("R7 disabled dropped");
    pend_i = '0; en_i = '0;
    pend_i[239] = 1'b1; en_i[239] = 1'b1;
    @(negedge clk_i);
    win_chk("R7 top index");
    pend_i = '0;
    @(negedge clk_i);
    win_chk("R9 none");
  endtask

  initial begin
    for (int i = 0; i < N; i++) prio_m[i] = 8'h00;
    rst_ni = 1'b0; req_i = 1'b0; we_i = 1'b0; priv_i = 1'b0; addr_i = '0;
    be_i = '0; wdata_i = '0; pend_i = '0; en_i = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    t_reset();
    t_map();
    t_nibble();
    t_be();
    t_unpriv();
    t_range();
    t_arb();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule